// File: doc/BRIEF.md
# Processor system control register unit

This block holds the system control state of a 32-bit processor core. It keeps four machine status bits: protection enable, monitor coprocessor, emulate coprocessor and task switched. It also keeps a page fault linear address register and a page directory base register. The instruction decoder gives it opcode-class strobes. The block answers at once whether the current coprocessor escape or WAIT opcode must take the coprocessor-not-available exception.

Software reaches the status bits through two load paths. The narrow legacy path can set protection enable but can never clear it. The full path writes all four bits freely. The paging unit is told to flush its translation cache through a one-cycle pulse. An explicit base write always raises this pulse. A task switch raises it only when the task brings in a different base. The task-switched bit is set in hardware on every task switch, and the handler clears it later through the full path.

Top module: `sysctl_unit`

## Requirements
- R1: After synchronous reset (rst high at a rising edge), status_word, pdb_q and pf_addr_q are all zero and tlb_flush is 0.
- R2: A task_switch strobe sampled at a rising edge leaves status bit 3 (task switched) at 1 after that edge.
- R3: While esc_op is high, nm_trap is 1 and trap_vector is 7 exactly when status bit 2 (emulate) or status bit 3 (task switched) is 1. Otherwise nm_trap is 0 and trap_vector is 0. Both outputs are combinational.
- R4: While wait_op is high and esc_op is low, nm_trap is 1 (trap_vector 7) only when status bit 1 (monitor) and status bit 3 are both 1. The emulate bit has no effect on this decision.
- R5: A legacy load (sw_load) writes sw_data[3:1] into status bits 3:1. Bit 0 becomes the OR of its old value and sw_data[0], so a legacy load never clears protection enable. Status bits 31:4 always read zero.
- R6: A full load (full_load) writes full_data[3:0] into status bits 3:0 and can clear bit 0. full_data[31:4] is ignored.
- R7: pdb_q holds written bits 31:12 and always reads zero in bits 11:0, whatever was written there.
- R8: A pdb_write raises tlb_flush for exactly the one cycle after the edge, even if the written value equals the stored one.
- R9: A task_switch loads ts_pdb[31:12] into the base. It raises tlb_flush for one cycle only when those bits differ from the stored base.
- R10: On pf_valid, pf_addr_q captures all 32 bits of pf_fault_addr and holds them until the next pf_valid.
- R11: When strobes coincide, full_load wins over sw_load, and a task_switch sets status bit 3 over whatever either load writes. A pdb_write wins over the task-switch base, and its flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sw_load | input | 1 | Legacy status load strobe |
| sw_data | input | 4 | Legacy status load value |
| full_load | input | 1 | Full status register load strobe |
| full_data | input | 32 | Full status register load value |
| task_switch | input | 1 | Task switch performed |
| ts_pdb | input | 32 | Page directory base carried by the task switch |
| pdb_write | input | 1 | Explicit page directory base write |
| pdb_data | input | 32 | Explicit base write value |
| pf_valid | input | 1 | Page fault detected |
| pf_fault_addr | input | 32 | Linear address of the fault |
| esc_op | input | 1 | Coprocessor escape opcode presented |
| wait_op | input | 1 | WAIT opcode presented |
| status_word | output | 32 | Status register, bits 3:0 = TS, EM, MP, PE (bit 3 down to bit 0) |
| pdb_q | output | 32 | Page directory base, low 12 bits zero |
| pf_addr_q | output | 32 | Last page fault linear address |
| tlb_flush | output | 1 | One-cycle translation cache flush request |
| nm_trap | output | 1 | Coprocessor-not-available exception request |
| trap_vector | output | 8 | 7 while nm_trap is 1, else 0 |

## Verification
A table of status settings is applied with each opcode class to separate the escape rule from the WAIT rule. A design that let emulate gate WAIT, or that trapped WAIT on task switched alone, would raise nm_trap where the table expects none. The legacy path is driven with protection enable cleared while it is already set; a design that took the bit as written would drop to zero. Base writes repeat an identical value, and task switches bring in both a same-page and a new base. A design that compared values on explicit writes, or flushed on every switch, would show the wrong tlb_flush pulse. Coinciding strobes and idle cycles after a fault check priority, and check that the fault address holds.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DATA_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int BASE_W     = DATA_W - PAGE_SHIFT;
    localparam int STAT_W     = 4;
    localparam int VEC_W      = 8;
    localparam logic [VEC_W-1:0] NM_VECTOR = VEC_W'(7);

    // bit 0 is protection enable, bit 3 task switched
    typedef struct packed {
        logic ts;
        logic em;
        logic mp;
        logic pe;
    } status_t;

    function automatic logic [DATA_W-1:0] status_to_word(input status_t s);
        return {{(DATA_W-STAT_W){1'b0}}, s};
    endfunction

    function automatic logic [DATA_W-1:0] base_to_word(input logic [BASE_W-1:0] b);
        return {b, {PAGE_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/sysctl_status.sv
module sysctl_status
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_load,
    input  logic [STAT_W-1:0] sw_data,
    input  logic              full_load,
    input  logic [STAT_W-1:0] full_data,
    input  logic              task_switch,
    output status_t           st_q
);
    status_t st_nxt;

    always_comb begin
        st_nxt = st_q;
        if (full_load) begin
            st_nxt = status_t'(full_data);
        end else if (sw_load) begin
            st_nxt    = status_t'(sw_data);
            st_nxt.pe = st_q.pe | sw_data[0];
        end
        if (task_switch) begin
            st_nxt.ts = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_nxt;
    end
endmodule

// File: rtl/sysctl_pdb.sv
module sysctl_pdb
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pdb_write,
    input  logic [DATA_W-1:0] pdb_data,
    input  logic              task_switch,
    input  logic [DATA_W-1:0] ts_pdb,
    output logic [BASE_W-1:0] base_q,
    output logic              flush_q
);
    logic [BASE_W-1:0] wr_base;
    logic [BASE_W-1:0] ts_base;
    logic              unused_low;

    assign wr_base    = pdb_data[DATA_W-1:PAGE_SHIFT];
    assign ts_base    = ts_pdb[DATA_W-1:PAGE_SHIFT];
    assign unused_low = ^{pdb_data[PAGE_SHIFT-1:0], ts_pdb[PAGE_SHIFT-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            flush_q <= 1'b0;
        end else if (pdb_write) begin
            base_q  <= wr_base;
            flush_q <= 1'b1;
        end else if (task_switch) begin
            base_q  <= ts_base;
            flush_q <= (ts_base != base_q);
        end else begin
            flush_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sysctl_pfa.sv
module sysctl_pfa
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pf_valid,
    input  logic [DATA_W-1:0] pf_fault_addr,
    output logic [DATA_W-1:0] pf_addr_q
);
    always_ff @(posedge clk) begin
        if (rst)           pf_addr_q <= '0;
        else if (pf_valid) pf_addr_q <= pf_fault_addr;
    end
endmodule

// File: rtl/sysctl_trap.sv
module sysctl_trap
    import sysctl_pkg::*;
(
    input  status_t          st,
    input  logic             esc_op,
    input  logic             wait_op,
    output logic             nm_trap,
    output logic [VEC_W-1:0] trap_vector
);
    logic esc_fault;
    logic wait_fault;

    always_comb begin
        esc_fault   = esc_op & (st.em | st.ts);
        wait_fault  = wait_op & st.mp & st.ts;
        nm_trap     = esc_fault | wait_fault;
        trap_vector = nm_trap ? NM_VECTOR : '0;
    end
endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_load,
    input  logic [STAT_W-1:0] sw_data,
    input  logic              full_load,
    input  logic [DATA_W-1:0] full_data,
    input  logic              task_switch,
    input  logic [DATA_W-1:0] ts_pdb,
    input  logic              pdb_write,
    input  logic [DATA_W-1:0] pdb_data,
    input  logic              pf_valid,
    input  logic [DATA_W-1:0] pf_fault_addr,
    input  logic              esc_op,
    input  logic              wait_op,
    output logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] pdb_q,
    output logic [DATA_W-1:0] pf_addr_q,
    output logic              tlb_flush,
    output logic              nm_trap,
    output logic [VEC_W-1:0]  trap_vector
);
    status_t           st_q;
    logic [BASE_W-1:0] base_q;
    logic              unused_full;

    assign unused_full = ^full_data[DATA_W-1:STAT_W];

    sysctl_status u_status (
        .clk(clk), .rst(rst),
        .sw_load(sw_load), .sw_data(sw_data),
        .full_load(full_load), .full_data(full_data[STAT_W-1:0]),
        .task_switch(task_switch), .st_q(st_q)
    );

    sysctl_pdb u_pdb (
        .clk(clk), .rst(rst),
        .pdb_write(pdb_write), .pdb_data(pdb_data),
        .task_switch(task_switch), .ts_pdb(ts_pdb),
        .base_q(base_q), .flush_q(tlb_flush)
    );

    sysctl_pfa u_pfa (
        .clk(clk), .rst(rst),
        .pf_valid(pf_valid), .pf_fault_addr(pf_fault_addr),
        .pf_addr_q(pf_addr_q)
    );

    sysctl_trap u_trap (
        .st(st_q), .esc_op(esc_op), .wait_op(wait_op),
        .nm_trap(nm_trap), .trap_vector(trap_vector)
    );

    assign status_word = status_to_word(st_q);
    assign pdb_q       = base_to_word(base_q);
endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sw_load,
    input logic              full_load,
    input logic              task_switch,
    input logic [DATA_W-1:0] ts_pdb,
    input logic              pdb_write,
    input logic              pf_valid,
    input logic              esc_op,
    input logic              wait_op,
    input logic [DATA_W-1:0] status_word,
    input logic [DATA_W-1:0] pdb_q,
    input logic [DATA_W-1:0] pf_addr_q,
    input logic              tlb_flush,
    input logic              nm_trap,
    input logic [VEC_W-1:0]  trap_vector
);
    AST_TS_ON_SWITCH: assert property (@(posedge clk) disable iff (rst)
        task_switch |=> status_word[3]); // R2

    AST_ESC_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (esc_op && (status_word[2] || status_word[3])) |-> (nm_trap && trap_vector == NM_VECTOR)); // R3

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wait_op && !esc_op && !(status_word[1] && status_word[3])) |-> !nm_trap); // R4

    AST_PE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sw_load && !full_load && status_word[0]) |=> status_word[0]); // R5

    AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        status_word[DATA_W-1:STAT_W] == '0); // R5

    AST_PDB_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        pdb_q[PAGE_SHIFT-1:0] == '0); // R7

    AST_FLUSH_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        pdb_write |=> tlb_flush); // R8

    AST_NO_FLUSH_SAME: assert property (@(posedge clk) disable iff (rst)
        (task_switch && !pdb_write && ts_pdb[DATA_W-1:PAGE_SHIFT] == pdb_q[DATA_W-1:PAGE_SHIFT]) |=> !tlb_flush); // R9

    AST_PF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pf_valid |=> $stable(pf_addr_q)); // R10
endmodule

bind sysctl_unit sysctl_checker i_chk (
    .clk(clk), .rst(rst), .sw_load(sw_load), .full_load(full_load),
    .task_switch(task_switch), .ts_pdb(ts_pdb), .pdb_write(pdb_write),
    .pf_valid(pf_valid), .esc_op(esc_op), .wait_op(wait_op),
    .status_word(status_word), .pdb_q(pdb_q), .pf_addr_q(pf_addr_q),
    .tlb_flush(tlb_flush), .nm_trap(nm_trap), .trap_vector(trap_vector)
);

// File: tb/test_sysctl_unit.sv
`timescale 1ns/1ps
module test_sysctl_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        sw_load, full_load, task_switch, pdb_write, pf_valid, esc_op, wait_op;
    logic [3:0]  sw_data;
    logic [31:0] full_data, ts_pdb, pdb_data, pf_fault_addr;
    logic [31:0] status_word, pdb_q, pf_addr_q;
    logic        tlb_flush, nm_trap;
    logic [7:0]  trap_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sysctl_unit i_sysctl_unit (
        .clk(clk), .rst(rst), .sw_load(sw_load), .sw_data(sw_data),
        .full_load(full_load), .full_data(full_data), .task_switch(task_switch),
        .ts_pdb(ts_pdb), .pdb_write(pdb_write), .pdb_data(pdb_data),
        .pf_valid(pf_valid), .pf_fault_addr(pf_fault_addr), .esc_op(esc_op),
        .wait_op(wait_op), .status_word(status_word), .pdb_q(pdb_q),
        .pf_addr_q(pf_addr_q), .tlb_flush(tlb_flush), .nm_trap(nm_trap),
        .trap_vector(trap_vector)
    );

    // row: {mp, em, ts, esc, wait, expected trap}
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        6'b000_10_0, 6'b010_10_1, 6'b001_10_1, 6'b111_10_1,
        6'b010_01_0, 6'b100_01_0, 6'b001_01_0, 6'b101_01_1,
        6'b111_01_1, 6'b110_01_0, 6'b000_01_0, 6'b100_10_0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        sw_load = 0; full_load = 0; task_switch = 0; pdb_write = 0;
        pf_valid = 0; esc_op = 0; wait_op = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        sw_data = 0; full_data = 0; ts_pdb = 0; pdb_data = 0; pf_fault_addr = 0;
        rst = 1;
        tick(); tick();
        rst = 0;
        // R1 reset state
        chk("R1 status", status_word, 32'h0);
        chk("R1 pdb", pdb_q, 32'h0);
        chk("R1 pfa", pf_addr_q, 32'h0);
        chk("R1 flush", {31'b0, tlb_flush}, 32'h0);
        esc_op = 1; #1;
        chk("R1 esc no trap", {31'b0, nm_trap}, 32'h0);
        esc_op = 0;

        // R3 R4 trap table
        for (int i = 0; i < NV; i++) begin
            full_data = {28'b0, VEC[i][3], VEC[i][4], VEC[i][5], 1'b0};
            full_load = 1; tick(); full_load = 0;
            esc_op = VEC[i][2]; wait_op = VEC[i][1]; #1;
            chk(VEC[i][2] ? "R3 esc trap" : "R4 wait trap", {31'b0, nm_trap}, {31'b0, VEC[i][0]});
            chk(VEC[i][2] ? "R3 vector" : "R4 vector", {24'b0, trap_vector}, VEC[i][0] ? 32'd7 : 32'd0);
            esc_op = 0; wait_op = 0;
        end

        // R5 legacy load
        full_data = 0; full_load = 1; tick(); full_load = 0;
        sw_data = 4'b0001; sw_load = 1; tick(); sw_load = 0;
        chk("R5 legacy sets PE", status_word, 32'h1);
        sw_data = 4'b0000; sw_load = 1; tick(); sw_load = 0;
        chk("R5 legacy cannot clear PE", status_word, 32'h1);
        sw_data = 4'b1110; sw_load = 1; tick(); sw_load = 0;
        chk("R5 legacy upper bits", status_word, 32'hF);

        // R6 full load
        full_data = 32'h0; full_load = 1; tick(); full_load = 0;
        chk("R6 full clears PE", status_word, 32'h0);
        full_data = 32'hFFFF_FFF5; full_load = 1; tick(); full_load = 0;
        chk("R6 full ignores high bits", status_word, 32'h5);

        // R2 task switch, R9 same base
        ts_pdb = 32'h0000_0ABC; task_switch = 1; tick(); task_switch = 0;
        chk("R2 ts set", status_word, 32'hD);
        chk("R9 same base no flush", {31'b0, tlb_flush}, 32'h0);

        // R11 load priority
        full_data = 32'h0; sw_data = 4'hF; full_load = 1; sw_load = 1; task_switch = 1;
        tick(); idle();
        chk("R11 full wins, ts forced", status_word, 32'h8);

        // R7 R8 explicit base write
        pdb_data = 32'h1234_5ABC; pdb_write = 1; tick(); pdb_write = 0;
        chk("R7 base low zero", pdb_q, 32'h1234_5000);
        chk("R8 flush on write", {31'b0, tlb_flush}, 32'h1);
        tick();
        chk("R8 flush one cycle", {31'b0, tlb_flush}, 32'h0);
        pdb_write = 1; tick(); pdb_write = 0;
        chk("R8 flush on same value", {31'b0, tlb_flush}, 32'h1);
        tick();

        // R9 task switch bases
        ts_pdb = 32'h1234_5FFF; task_switch = 1; tick(); task_switch = 0;
        chk("R9 same page no flush", {31'b0, tlb_flush}, 32'h0);
        chk("R9 base kept", pdb_q, 32'h1234_5000);
        ts_pdb = 32'hABCD_E123; task_switch = 1; tick(); task_switch = 0;
        chk("R9 new base flush", {31'b0, tlb_flush}, 32'h1);
        chk("R9 new base loaded", pdb_q, 32'hABCD_E000);
        tick();
        chk("R9 flush one cycle", {31'b0, tlb_flush}, 32'h0);

        // R11 base priority
        pdb_data = 32'h1111_1000; ts_pdb = 32'h2222_2000;
        pdb_write = 1; task_switch = 1; tick(); idle();
        chk("R11 write wins base", pdb_q, 32'h1111_1000);
        chk("R11 write flush", {31'b0, tlb_flush}, 32'h1);

        // R10 fault address
        pf_fault_addr = 32'hDEAD_BEEF; pf_valid = 1; tick(); pf_valid = 0;
        pf_fault_addr = 32'h5555_5555;
        chk("R10 capture", pf_addr_q, 32'hDEAD_BEEF);
        tick(); tick();
        chk("R10 hold", pf_addr_q, 32'hDEAD_BEEF);
        pf_fault_addr = 32'h0000_0FFF; pf_valid = 1; tick(); pf_valid = 0;
        chk("R10 recapture", pf_addr_q, 32'h0000_0FFF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule